// File: doc/BRIEF.md
# Banked Program Memory Address Mapper

This block turns a 12-bit program counter into a physical address into a program ROM that is larger than the counter can reach on its own. The counter's address space is split in two equal halves. Fetches from the upper half always land on one fixed ROM page. Fetches from the lower half land on whichever 2-kbyte page a memory-mapped bank register currently names. With ten pages, 20 kbytes of ROM are reachable.

A second path lets ordinary data reads fetch constants from the ROM. A 64-byte region of the data address space acts as a window. A window register picks which 64-byte ROM segment shows through it, and the low six data address bits select the byte inside that segment.

Both registers are loaded through a simple write strobe with an address and a data byte. Both translated addresses are registered, so each result appears one clock after the request that produced it.

Top module: `pmem_bank_mapper`

## Requirements
- R1: After reset `fetch_addr`, `tbl_addr`, `tbl_hit` and `bank_bad` are zero, and both the bank register and the window register hold zero. A lower-half fetch therefore maps to page 0 and a window read maps to segment 0.
- R2: A fetch with `pc[11]`=0 yields `fetch_addr` = bank page × 2048 + `pc[10:0]` on the clock edge that samples it, so the result is visible one cycle after the request.
- R3: A fetch with `pc[11]`=1 yields `fetch_addr` = `FIXED_PAGE` (default 1) × 2048 + `pc[10:0]`, whatever the bank register holds.
- R4: A write with `wr_addr`=0xD8 loads the bank register from `wr_data[3:0]`. Bits 7:4 of the write data are ignored.
- R5: A stored bank value of 10 to 15 is clamped, so lower-half fetches use page 9. `bank_bad` is 1 for exactly as long as such a value is stored.
- R6: A fetch or window read sampled on the same edge as a write to its register uses the old register value. The new value applies from the next request onward.
- R7: A read (`data_rd`=1) whose `data_addr` lies in 0x40..0x7F gives `tbl_hit`=1 one cycle later, with `tbl_addr` = window register × 64 + `data_addr[5:0]`. The window register is written at `wr_addr`=0xD9 from all eight data bits.
- R8: A read outside 0x40..0x7F, or any cycle with `data_rd`=0, gives `tbl_hit`=0 and `tbl_addr`=0 one cycle later.
- R9: A write to any address other than 0xD8 or 0xD9 changes neither register, and a cycle with `wr_en`=0 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | 12 | Program counter of the current fetch |
| data_rd | input | 1 | Data read request |
| data_addr | input | 8 | Data address of the read |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| fetch_addr | output | 15 | Physical ROM address of the fetch |
| bank_bad | output | 1 | Bank register holds an out-of-range page |
| tbl_hit | output | 1 | Previous data read hit the ROM window |
| tbl_addr | output | 15 | Physical ROM address of the window read |

## Verification
Each fetch, window read and register write is driven on a falling edge. The result it produces is due just after the next rising edge. That holds for `fetch_addr`, `tbl_hit` and `tbl_addr`, and also for `bank_bad`, which follows the register that the same edge has just loaded. The driver records the expected outcome with the register values from before the write for the addresses, and with the value after the write for `bank_bad`. The monitor compares two time units after each rising edge, so every result is checked in the exact cycle it is due, and a write that took effect one cycle early or late shows up as a miscompare.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

   // which mapper register a write strobe targets
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_BANK = 2'd1,
      SEL_WIN  = 2'd2
   } pbm_sel_e;

   // page chosen for a program fetch, before concatenation with the offset
   typedef enum logic {
      HALF_BANKED = 1'b0,
      HALF_FIXED  = 1'b1
   } pbm_half_e;

endpackage

// File: rtl/pbm_regs.sv
module pbm_regs
   import pbm_pkg::*;
#(
   parameter int unsigned                DA_W      = 8,
   parameter int unsigned                DW        = 8,
   parameter int unsigned                BANK_W    = 4,
   parameter int unsigned                WSEL_W    = 8,
   parameter logic [DA_W-1:0]            BANK_ADDR = 8'hD8,
   parameter logic [DA_W-1:0]            WIN_ADDR  = 8'hD9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DA_W-1:0]   wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic [BANK_W-1:0] bank_q,
   output logic [WSEL_W-1:0] win_q
);

   pbm_sel_e sel;

   always_comb begin
      sel = SEL_NONE;
      if (wr_en) begin
         if (wr_addr == BANK_ADDR)     sel = SEL_BANK;
         else if (wr_addr == WIN_ADDR) sel = SEL_WIN;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bank_q <= '0;
      end else if (sel == SEL_BANK) begin
         bank_q <= wr_data[BANK_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q <= '0;
      end else if (sel == SEL_WIN) begin
         win_q <= wr_data[WSEL_W-1:0];
      end
   end

endmodule

// File: rtl/pbm_prog_xlate.sv
module pbm_prog_xlate
   import pbm_pkg::*;
#(
   parameter int unsigned PC_W       = 12,
   parameter int unsigned NUM_PAGES  = 10,
   parameter int unsigned FIXED_PAGE = 1,
   parameter int unsigned BANK_W     = 4,
   parameter bit          CLAMP_EN   = 1'b1,
   localparam int unsigned OFS_W     = PC_W - 1,
   localparam int unsigned PHYS_W    = BANK_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PC_W-1:0]   pc,
   input  logic [BANK_W-1:0] bank_q,
   output logic [PHYS_W-1:0] fetch_addr,
   output logic              bank_bad
);

   localparam logic [BANK_W-1:0] LAST_PAGE = BANK_W'(NUM_PAGES - 1);
   localparam logic [BANK_W-1:0] FIX_PAGE  = BANK_W'(FIXED_PAGE);

   logic              over;
   logic [BANK_W-1:0] eff_bank;
   logic [BANK_W-1:0] page;
   pbm_half_e         half;

   assign over     = (bank_q > LAST_PAGE);
   assign bank_bad = over;

   generate
      if (CLAMP_EN) begin : g_clamp
         assign eff_bank = over ? LAST_PAGE : bank_q;
      end else begin : g_wrap
         assign eff_bank = bank_q;
      end
   endgenerate

   assign half = pbm_half_e'(pc[PC_W-1]);

   always_comb begin
      unique case (half)
         HALF_FIXED:  page = FIX_PAGE;
         default:     page = eff_bank;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fetch_addr <= '0;
      end else begin
         fetch_addr <= {page, pc[OFS_W-1:0]};
      end
   end

endmodule

// File: rtl/pbm_tbl_xlate.sv
module pbm_tbl_xlate #(
   parameter int unsigned     DA_W      = 8,
   parameter int unsigned     WIN_OFS_W = 6,
   parameter int unsigned     WSEL_W    = 8,
   parameter int unsigned     PHYS_W    = 15,
   parameter logic [DA_W-1:0] WIN_BASE  = 8'h40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              data_rd,
   input  logic [DA_W-1:0]   data_addr,
   input  logic [WSEL_W-1:0] win_q,
   output logic              tbl_hit,
   output logic [PHYS_W-1:0] tbl_addr
);

   localparam int unsigned TAG_W = DA_W - WIN_OFS_W;
   localparam int unsigned RAW_W = WSEL_W + WIN_OFS_W;
   localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[DA_W-1:WIN_OFS_W];

   logic              hit;
   logic [RAW_W-1:0]  raw;
   logic [PHYS_W-1:0] phys;

   assign hit = data_rd && (data_addr[DA_W-1:WIN_OFS_W] == WIN_TAG);
   assign raw = {win_q, data_addr[WIN_OFS_W-1:0]};

   generate
      if (RAW_W < PHYS_W) begin : g_pad
         assign phys = {{(PHYS_W - RAW_W){1'b0}}, raw};
      end else begin : g_trunc
         assign phys = raw[PHYS_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         tbl_hit  <= 1'b0;
         tbl_addr <= '0;
      end else begin
         tbl_hit  <= hit;
         tbl_addr <= hit ? phys : '0;
      end
   end

endmodule

// File: rtl/pmem_bank_mapper.sv
module pmem_bank_mapper #(
   parameter int unsigned     PC_W       = 12,
   parameter int unsigned     NUM_PAGES  = 10,
   parameter int unsigned     FIXED_PAGE = 1,
   parameter int unsigned     DA_W       = 8,
   parameter int unsigned     DW         = 8,
   parameter int unsigned     WIN_OFS_W  = 6,
   parameter logic [DA_W-1:0] WIN_BASE   = 8'h40,
   parameter logic [DA_W-1:0] BANK_ADDR  = 8'hD8,
   parameter logic [DA_W-1:0] WIN_ADDR   = 8'hD9,
   parameter bit              CLAMP_EN   = 1'b1,
   localparam int unsigned    BANK_W     = $clog2(NUM_PAGES),
   localparam int unsigned    PHYS_W     = BANK_W + PC_W - 1,
   localparam int unsigned    WSEL_W     = DW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PC_W-1:0]   pc,
   input  logic              data_rd,
   input  logic [DA_W-1:0]   data_addr,
   input  logic              wr_en,
   input  logic [DA_W-1:0]   wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic [PHYS_W-1:0] fetch_addr,
   output logic              bank_bad,
   output logic              tbl_hit,
   output logic [PHYS_W-1:0] tbl_addr
);

   // elaboration-time parameter checks
   generate
      if (NUM_PAGES < 2) begin : g_err_pages
         $error("pmem_bank_mapper: NUM_PAGES must be at least 2");
      end
      if (FIXED_PAGE >= NUM_PAGES) begin : g_err_fixed
         $error("pmem_bank_mapper: FIXED_PAGE out of range");
      end
      if (BANK_W > DW) begin : g_err_bankw
         $error("pmem_bank_mapper: bank field wider than write data");
      end
      if (WIN_OFS_W >= DA_W) begin : g_err_win
         $error("pmem_bank_mapper: window wider than data space");
      end
      if ((WIN_BASE % (1 << WIN_OFS_W)) != 0) begin : g_err_align
         $error("pmem_bank_mapper: WIN_BASE not aligned to window size");
      end
      if (BANK_ADDR == WIN_ADDR) begin : g_err_alias
         $error("pmem_bank_mapper: register addresses collide");
      end
   endgenerate

   logic [BANK_W-1:0] bank_q;
   logic [WSEL_W-1:0] win_q;

   pbm_regs #(
      .DA_W      (DA_W),
      .DW        (DW),
      .BANK_W    (BANK_W),
      .WSEL_W    (WSEL_W),
      .BANK_ADDR (BANK_ADDR),
      .WIN_ADDR  (WIN_ADDR)
   ) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .bank_q  (bank_q),
      .win_q   (win_q)
   );

   pbm_prog_xlate #(
      .PC_W       (PC_W),
      .NUM_PAGES  (NUM_PAGES),
      .FIXED_PAGE (FIXED_PAGE),
      .BANK_W     (BANK_W),
      .CLAMP_EN   (CLAMP_EN)
   ) u_prog (
      .clk        (clk),
      .rst        (rst),
      .pc         (pc),
      .bank_q     (bank_q),
      .fetch_addr (fetch_addr),
      .bank_bad   (bank_bad)
   );

   pbm_tbl_xlate #(
      .DA_W      (DA_W),
      .WIN_OFS_W (WIN_OFS_W),
      .WSEL_W    (WSEL_W),
      .PHYS_W    (PHYS_W),
      .WIN_BASE  (WIN_BASE)
   ) u_tbl (
      .clk       (clk),
      .rst       (rst),
      .data_rd   (data_rd),
      .data_addr (data_addr),
      .win_q     (win_q),
      .tbl_hit   (tbl_hit),
      .tbl_addr  (tbl_addr)
   );

endmodule

// File: rtl/pbm_chk.sv
module pbm_chk #(
   parameter int unsigned PC_W       = 12,
   parameter int unsigned NUM_PAGES  = 10,
   parameter int unsigned FIXED_PAGE = 1,
   parameter int unsigned DA_W       = 8,
   parameter int unsigned DW         = 8,
   parameter int unsigned WIN_OFS_W  = 6,
   parameter int unsigned PHYS_W     = 15
) (
   input logic              clk,
   input logic              rst,
   input logic [PC_W-1:0]   pc,
   input logic              data_rd,
   input logic [DA_W-1:0]   data_addr,
   input logic              wr_en,
   input logic [DA_W-1:0]   wr_addr,
   input logic [DW-1:0]     wr_data,
   input logic [PHYS_W-1:0] fetch_addr,
   input logic              bank_bad,
   input logic              tbl_hit,
   input logic [PHYS_W-1:0] tbl_addr
);

   localparam int unsigned OFS_W  = PC_W - 1;
   localparam int unsigned PAGE_W = PHYS_W - OFS_W;
   localparam logic [PAGE_W-1:0] FIX_PG  = PAGE_W'(FIXED_PAGE);
   localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(NUM_PAGES - 1);

   // set once a full clock has passed outside reset, so $past is meaningful
   logic live;
   always_ff @(posedge clk) begin
      if (rst) live <= 1'b0;
      else     live <= 1'b1;
   end

   a_r3_fixed_upper: assert property (@(posedge clk) disable iff (rst)
      (live && $past(pc[PC_W-1])) |-> (fetch_addr[PHYS_W-1:OFS_W] == FIX_PG));

   a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst)
      live |-> (fetch_addr[OFS_W-1:0] == $past(pc[OFS_W-1:0])));

   a_r5_page_in_range: assert property (@(posedge clk) disable iff (rst)
      fetch_addr[PHYS_W-1:OFS_W] <= LAST_PG);

   a_r7_hit_needs_read: assert property (@(posedge clk) disable iff (rst)
      (live && tbl_hit) |-> $past(data_rd));

   a_r7_offset_pass: assert property (@(posedge clk) disable iff (rst)
      (live && tbl_hit) |-> (tbl_addr[WIN_OFS_W-1:0] == $past(data_addr[WIN_OFS_W-1:0])));

   a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
      !tbl_hit |-> (tbl_addr == '0));

   a_r9_bad_holds: assert property (@(posedge clk) disable iff (rst)
      (live && !$past(wr_en)) |-> $stable(bank_bad));

endmodule

bind pmem_bank_mapper pbm_chk #(
   .PC_W       (PC_W),
   .NUM_PAGES  (NUM_PAGES),
   .FIXED_PAGE (FIXED_PAGE),
   .DA_W       (DA_W),
   .DW         (DW),
   .WIN_OFS_W  (WIN_OFS_W),
   .PHYS_W     (PHYS_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .pc         (pc),
   .data_rd    (data_rd),
   .data_addr  (data_addr),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .fetch_addr (fetch_addr),
   .bank_bad   (bank_bad),
   .tbl_hit    (tbl_hit),
   .tbl_addr   (tbl_addr)
);

// File: tb/pmem_bank_mapper_test.sv
module pmem_bank_mapper_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] pc = '0;
   logic        data_rd = 1'b0;
   logic [7:0]  data_addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [14:0] fetch_addr;
   logic        bank_bad;
   logic        tbl_hit;
   logic [14:0] tbl_addr;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   pmem_bank_mapper uut (
      .clk        (clk),
      .rst        (rst),
      .pc         (pc),
      .data_rd    (data_rd),
      .data_addr  (data_addr),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .fetch_addr (fetch_addr),
      .bank_bad   (bank_bad),
      .tbl_hit    (tbl_hit),
      .tbl_addr   (tbl_addr)
   );

   typedef struct packed {
      logic [14:0] fa;
      logic        bad;
      logic        hit;
      logic [14:0] ta;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   // reference model state
   int m_bank = 0;
   int m_win  = 0;

   function automatic logic [14:0] ref_fetch(input logic [11:0] p, input int bank);
      int page;
      if (p[11]) page = 1;
      else       page = (bank > 9) ? 9 : bank;
      return 15'(page * 2048 + int'(p[10:0]));
   endfunction

   // driver: applies one request on a falling edge, records the expected result
   task automatic step(input logic [11:0] p, input logic rd, input logic [7:0] da,
                       input logic we, input logic [7:0] wa, input logic [7:0] wd,
                       input string tag);
      exp_t e;
      @(negedge clk);
      pc = p; data_rd = rd; data_addr = da;
      wr_en = we; wr_addr = wa; wr_data = wd;
      e.fa  = ref_fetch(p, m_bank);
      e.hit = rd && (da >= 8'h40) && (da <= 8'h7F);
      e.ta  = e.hit ? 15'(m_win * 64 + int'(da[5:0])) : 15'd0;
      if (we && wa == 8'hD8) m_bank = int'(wd[3:0]);
      if (we && wa == 8'hD9) m_win  = int'(wd);
      e.bad = (m_bank > 9);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: compares each result just after the edge on which it is due
   always @(posedge clk) begin
      #2;
      if (!rst && exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         vectors++;
         if (fetch_addr !== e.fa || bank_bad !== e.bad ||
             tbl_hit !== e.hit || tbl_addr !== e.ta) begin
            fails++;
            $display("FAIL %s: got fa=%h bad=%b hit=%b ta=%h, expected fa=%h bad=%b hit=%b ta=%h",
                     t, fetch_addr, bank_bad, tbl_hit, tbl_addr,
                     e.fa, e.bad, e.hit, e.ta);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs clear while in reset and right after it
      vectors++;
      if (fetch_addr !== '0 || bank_bad !== 1'b0 || tbl_hit !== 1'b0 || tbl_addr !== '0) begin
         fails++;
         $display("FAIL R1 reset: got fa=%h bad=%b hit=%b ta=%h, expected all zero",
                  fetch_addr, bank_bad, tbl_hit, tbl_addr);
      end
      rst = 1'b0;

      // R1 registers start at zero; R2 lower half, R7 window read
      step(12'h123, 1'b1, 8'h45, 1'b0, 8'h00, 8'h00, "R1 R2 R7 zero bank and window");
      // R6: bank write in same cycle as fetch keeps old page
      step(12'h010, 1'b0, 8'h00, 1'b1, 8'hD8, 8'h03, "R6 same-cycle bank write");
      step(12'h010, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R2 bank 3 applied");
      // R3: upper half ignores bank
      step(12'h9AB, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R3 upper half fixed");
      step(12'hFFF, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R3 top address");
      // R4: upper data bits ignored
      step(12'h000, 1'b0, 8'h00, 1'b1, 8'hD8, 8'h75, "R4 write 0x75");
      step(12'h7FF, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R4 stored bank 5");
      // R5: clamp and status
      step(12'h001, 1'b0, 8'h00, 1'b1, 8'hD8, 8'h0C, "R5 write 12");
      step(12'h001, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R5 clamped to page 9");
      step(12'h801, 1'b0, 8'h00, 1'b1, 8'hD8, 8'h0F, "R5 write 15");
      step(12'h2AA, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R5 still clamped");
      // R9: other addresses and idle strobe leave registers alone
      step(12'h2AA, 1'b0, 8'h00, 1'b1, 8'hDA, 8'h02, "R9 write elsewhere");
      step(12'h2AA, 1'b0, 8'h00, 1'b0, 8'hD8, 8'h02, "R9 strobe low");
      step(12'h2AA, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R9 bank unchanged");
      step(12'h000, 1'b0, 8'h00, 1'b1, 8'hD8, 8'h09, "R5 write 9 clears status");
      step(12'h555, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R5 page 9 valid");
      step(12'h555, 1'b0, 8'h00, 1'b1, 8'hD8, 8'h0A, "R5 write 10 boundary");
      // R6 for window; R7 window mapping
      step(12'h000, 1'b1, 8'h7F, 1'b1, 8'hD9, 8'h2A, "R6 same-cycle window write");
      step(12'h000, 1'b1, 8'h41, 1'b0, 8'h00, 8'h00, "R7 window 0x2A");
      step(12'h000, 1'b1, 8'h40, 1'b0, 8'h00, 8'h00, "R7 window low edge");
      // R8: misses
      step(12'h000, 1'b1, 8'h3F, 1'b0, 8'h00, 8'h00, "R8 below window");
      step(12'h000, 1'b1, 8'h80, 1'b0, 8'h00, 8'h00, "R8 above window");
      step(12'h000, 1'b0, 8'h50, 1'b0, 8'h00, 8'h00, "R8 no read strobe");
      // R9 on window register, then full-range window
      step(12'h000, 1'b1, 8'h50, 1'b1, 8'hD7, 8'h11, "R9 window untouched");
      step(12'h000, 1'b1, 8'h50, 1'b1, 8'hD9, 8'hFF, "R7 load window 0xFF");
      step(12'h000, 1'b1, 8'h7F, 1'b0, 8'h00, 8'h00, "R7 top of ROM window");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: %0d results outstanding, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule